// File: doc/BRIEF.md
# Programmable SPI Serial Clock Generator

This block produces the serial clock of an SPI master from the system clock. A modulus counter divides the system clock. It also emits single-cycle strobes that tell a neighbouring shift register when to change outgoing data and when to capture incoming data. A transfer starts on a one-cycle run request. At that moment the block takes a divider value, a polarity bit, a phase bit and a bit count. It then makes two SCK edges per bit and ends with a one-cycle done pulse.

Each SCK half period lasts as many system clocks as the divider value, so the SCK period is twice the divider. Example division ratios are 4 for divider 2, 34 for divider 17, 168 for divider 84 and 510 for divider 255. Divider values below 2 turn the generator off, and SCK then stays at its idle level. The held settings reset to divider 4 and phase 1 (parameters `RST_DIV`, `RST_CPHA`). These reset values govern the block only until the first accepted run request, because every accepted request reloads the settings.

Top module: `spi_sck_gen`

## Requirements
- R1: During and right after reset, sck_o, busy_o, done_o, shift_o and sample_o are all 0.
- R2: While no transfer is running, sck_o equals the value cpol_i had one clock earlier.
- R3: A transfer accepted at clock edge P0 produces SCK edges at edges P0+d, P0+2d, and so on, where d is the divider value. Each half period is therefore d system clocks and the period is 2d. This holds for every d from 2 to 255.
- R4: A run request is ignored when div_i is 0 or 1, or when bits_i is 0. In that case busy_o, done_o and the strobes stay 0, and SCK stays at the idle level.
- R5: A transfer of B bits (bits_i = B, from 1 to 2^BITS_W-1) makes exactly 2B SCK edges. done_o is high for one cycle, in the cycle of the last edge. In that cycle busy_o is 0 and sck_o is back at the polarity that was captured.
- R6: With phase 0, sample_o marks the leading edges, which are the odd-numbered edges counted from 1. shift_o marks the trailing (even-numbered) edges.
- R7: With phase 1, shift_o marks the leading edges and sample_o marks the trailing edges.
- R8: While busy_o is high, changes on div_i, cpol_i, cpha_i, bits_i and start_i have no effect. Only the values present when the request was accepted apply.
- R9: Each strobe lasts one cycle and appears only in a cycle where sck_o has just changed. shift_o and sample_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W | Divider value; below 2 disables the generator |
| cpol_i | input | 1 | SCK idle level |
| cpha_i | input | 1 | Phase: 0 samples on the leading edge, 1 shifts on the leading edge |
| bits_i | input | BITS_W | Bits per transfer |
| start_i | input | 1 | Run request, accepted only when idle |
| sck_o | output | 1 | Serial clock |
| shift_o | output | 1 | One-cycle strobe: change outgoing data |
| sample_o | output | 1 | One-cycle strobe: capture incoming data |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The assertions check on every cycle that the idle SCK follows polarity, that strobes are exclusive, single-cycle and tied to an SCK change, that the spacing between edges equals the held divider, and that the held settings do not move during a transfer. They also check that done lands at the idle level and that requests with a divider below 2 never start a transfer. Only the bench scenarios can show the exact edge count per bit length and the edge-to-strobe mapping for both phases across dividers up to 255. The same applies to inputs that are scrambled during a transfer and have no effect.

// File: rtl/spi_sck_pkg.sv
package spi_sck_pkg;
  localparam int unsigned DIV_W    = 8;
  localparam int unsigned BITS_W   = 5;
  localparam int unsigned RST_DIV  = 4;
  localparam bit          RST_CPHA = 1'b1;
  localparam int unsigned MIN_DIV  = 2;
endpackage

// File: rtl/sck_prescaler.sv
module sck_prescaler #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/sck_edge_seq.sv
module sck_edge_seq #(
  parameter int unsigned EDGE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [EDGE_W-1:0] edges_i,
  input  logic              tick_i,
  input  logic              idle_pol_i,
  input  logic              cpha_i,
  output logic              busy_o,
  output logic              sck_o,
  output logic              shift_o,
  output logic              sample_o,
  output logic              done_o
);
  logic [EDGE_W-1:0] left_q;
  logic              lead_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o   <= 1'b0;
      sck_o    <= 1'b0;
      shift_o  <= 1'b0;
      sample_o <= 1'b0;
      done_o   <= 1'b0;
      left_q   <= '0;
      lead_q   <= 1'b1;
    end else begin
      shift_o  <= 1'b0;
      sample_o <= 1'b0;
      done_o   <= 1'b0;
      if (load_i) begin
        busy_o <= 1'b1;
        left_q <= edges_i;
        lead_q <= 1'b1;
        sck_o  <= idle_pol_i;
      end else if (busy_o && tick_i) begin
        sck_o    <= ~sck_o;
        lead_q   <= ~lead_q;
        left_q   <= left_q - EDGE_W'(1);
        // phase 1 launches on leading edges, phase 0 captures on them
        shift_o  <= cpha_i ? lead_q : ~lead_q;
        sample_o <= cpha_i ? ~lead_q : lead_q;
        if (left_q == EDGE_W'(1)) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end
      end else if (!busy_o) begin
        sck_o <= idle_pol_i;
      end
    end
  end
endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen
  import spi_sck_pkg::*;
#(
  parameter int unsigned DIV_W  = spi_sck_pkg::DIV_W,
  parameter int unsigned BITS_W = spi_sck_pkg::BITS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic [BITS_W-1:0] bits_i,
  input  logic              start_i,
  output logic              sck_o,
  output logic              shift_o,
  output logic              sample_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int unsigned EDGE_W = BITS_W + 1;

  logic [DIV_W-1:0] div_q;
  logic             cpol_q, cpha_q;
  logic             start_ok, tick;
  logic [EDGE_W-1:0] edges;

  assign start_ok = start_i && !busy_o && (div_i >= DIV_W'(MIN_DIV)) && (bits_i != '0);
  assign edges    = {bits_i, 1'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= DIV_W'(RST_DIV);
      cpha_q <= RST_CPHA;
      cpol_q <= 1'b0;
    end else if (start_ok) begin
      div_q  <= div_i;
      cpha_q <= cpha_i;
      cpol_q <= cpol_i;
    end
  end

  sck_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_o),
    .div_i  (div_q),
    .tick_o (tick)
  );

  sck_edge_seq #(.EDGE_W(EDGE_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start_ok),
    .edges_i    (edges),
    .tick_i     (tick),
    .idle_pol_i (busy_o ? cpol_q : cpol_i),
    .cpha_i     (cpha_q),
    .busy_o     (busy_o),
    .sck_o      (sck_o),
    .shift_o    (shift_o),
    .sample_o   (sample_o),
    .done_o     (done_o)
  );
endmodule

// File: rtl/spi_sck_gen_chk.sv
module spi_sck_gen_chk #(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned BITS_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DIV_W-1:0]  div_i,
  input logic              cpol_i,
  input logic              start_i,
  input logic              sck_o,
  input logic              shift_o,
  input logic              sample_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [DIV_W-1:0]  div_q,
  input logic              cpol_q,
  input logic              cpha_q
);
  logic             armed_q, busy_d;
  logic [DIV_W:0]   gap_q;
  logic             strobe;

  assign strobe = shift_o || sample_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      busy_d  <= 1'b0;
      gap_q   <= '0;
    end else begin
      armed_q <= 1'b1;
      busy_d  <= busy_o;
      if ((busy_o && !busy_d) || strobe) gap_q <= (DIV_W+1)'(1);
      else if (gap_q != '1)             gap_q <= gap_q + (DIV_W+1)'(1);
    end
  end

  p_idle_follows_pol_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !busy_o && !done_o && !$past(busy_o)) |-> sck_o == $past(cpol_i));

  p_half_period_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && strobe) |-> gap_q == {1'b0, div_q});

  p_bad_div_ignored_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && div_i < DIV_W'(2)) |=> !busy_o);

  p_done_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && sck_o == cpol_q && strobe));

  p_done_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_cfg_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && busy_o && $past(busy_o)) |-> ($stable(div_q) && $stable(cpol_q) && $stable(cpha_q)));

  p_strobe_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(shift_o && sample_o));

  p_strobe_on_edge_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && strobe) |-> sck_o != $past(sck_o));

  p_strobe_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe && div_q > DIV_W'(1)) |=> !strobe);

  p_sck_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && busy_o && $past(busy_o) && !strobe) |-> $stable(sck_o));
endmodule

bind spi_sck_gen spi_sck_gen_chk #(.DIV_W(DIV_W), .BITS_W(BITS_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .div_i    (div_i),
  .cpol_i   (cpol_i),
  .start_i  (start_i),
  .sck_o    (sck_o),
  .shift_o  (shift_o),
  .sample_o (sample_o),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .div_q    (div_q),
  .cpol_q   (cpol_q),
  .cpha_q   (cpha_q)
);

// File: tb/spi_sck_gen_test.sv
module spi_sck_gen_test;
  localparam int unsigned DIV_W  = 8;
  localparam int unsigned BITS_W = 5;
  localparam time         CLK_PERIOD = 10ns;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [DIV_W-1:0]  div_i = '0;
  logic              cpol_i = 1'b0;
  logic              cpha_i = 1'b0;
  logic [BITS_W-1:0] bits_i = '0;
  logic              start_i = 1'b0;
  logic sck_o, shift_o, sample_o, busy_o, done_o;

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_sck_gen #(.DIV_W(DIV_W), .BITS_W(BITS_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .div_i(div_i), .cpol_i(cpol_i), .cpha_i(cpha_i),
    .bits_i(bits_i), .start_i(start_i), .sck_o(sck_o), .shift_o(shift_o),
    .sample_o(sample_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // packed {busy, done, sck, shift, sample} expected k negedges after acceptance
  function automatic logic [4:0] exp_state(int k, int d, int b, bit p, bit h);
    int last = 2 * b * d + 1;
    int j    = (k - 1) / d;
    bit stb  = (k > 1) && ((k - 1) % d == 0);
    bit lead = (j % 2) == 1;
    bit sck  = p ^ lead;
    bit sh   = stb && (h ? lead : !lead);
    bit sa   = stb && (h ? !lead : lead);
    return {k < last, k == last, sck, sh, sa};
  endfunction

  task automatic run_xfer(input int d, input bit p, input bit h, input int b, input string req);
    int last = 2 * b * d + 1;
    @(negedge clk);
    div_i = DIV_W'(d); cpol_i = p; cpha_i = h; bits_i = BITS_W'(b); start_i = 1'b1;
    for (int k = 1; k <= last; k++) begin
      logic [4:0] e, a;
      @(negedge clk);
      e = exp_state(k, d, b, p, h);
      a = {busy_o, done_o, sck_o, shift_o, sample_o};
      check(a == e, req, 32'(a), 32'(e));
      // R8: scramble settings and re-request while running
      if (k < last - 1) begin
        div_i = DIV_W'($urandom); cpol_i = !p; cpha_i = !h;
        bits_i = BITS_W'($urandom); start_i = 1'($urandom);
      end else begin
        cpol_i = p; start_i = 1'b0;
      end
    end
    @(negedge clk);
    check(!busy_o && !done_o && !shift_o && !sample_o, {req, " R5 after done"},
          32'({busy_o, done_o, shift_o, sample_o}), 0);
  endtask

  task automatic try_ignored(input int d, input int b, input bit p);
    @(negedge clk);
    div_i = DIV_W'(d); bits_i = BITS_W'(b); cpol_i = p; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < 12; k++) begin
      check(!busy_o && !done_o && !shift_o && !sample_o && sck_o == p, "R4 ignored request",
            32'({busy_o, done_o, shift_o, sample_o, sck_o}), 32'(p));
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    cpol_i = 1'b1;
    repeat (3) @(negedge clk);
    check({sck_o, busy_o, done_o, shift_o, sample_o} == 5'b0, "R1 in reset",
          32'({sck_o, busy_o, done_o, shift_o, sample_o}), 0);
    cpol_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk);
    check({sck_o, busy_o, done_o, shift_o, sample_o} == 5'b0, "R1 after reset",
          32'({sck_o, busy_o, done_o, shift_o, sample_o}), 0);

    // R2 idle polarity tracking
    cpol_i = 1'b1;
    @(negedge clk);
    check(sck_o == 1'b1, "R2 idle high", 32'(sck_o), 1);
    cpol_i = 1'b0;
    @(negedge clk);
    check(sck_o == 1'b0, "R2 idle low", 32'(sck_o), 0);

    // directed divider examples and phases
    run_xfer(2,   0, 0, 3, "R3 R5 R6 div2");
    run_xfer(17,  1, 1, 2, "R3 R5 R7 div17");
    run_xfer(84,  0, 1, 1, "R3 R5 R7 div84");
    run_xfer(255, 1, 0, 2, "R3 R5 R6 div255");
    run_xfer(4,   0, 1, 31, "R5 R7 max bits");
    run_xfer(3,   1, 0, 1, "R5 R6 one bit");

    // R4 invalid settings
    try_ignored(0, 4, 1'b0);
    try_ignored(1, 4, 1'b1);
    try_ignored(9, 0, 1'b0);

    // random mix
    for (int i = 0; i < 30; i++) begin
      int d = 2 + int'($urandom % 40);
      int b = 1 + int'($urandom % 8);
      run_xfer(d, 1'($urandom), 1'($urandom), b, "R3 R5 R6 R7 R8 R9 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule